// File: doc/BRIEF.md
# Capability Permission Legalizer

This block narrows the permission set and level attached to a capability. A request carries the current permission flags, the store-level field and the level field, together with a mask operand of the same shape. The block ANDs each field with its mask. It then applies the dependency rules between permissions, so the result is always a legal set that is never stronger than the input.

The store-level field holds the complement of the lowest level that may be stored through the capability. Because of this encoding, an AND can only raise that threshold, and so it can only weaken the permission. The level field and the store-level field are both `LVL_W` bits wide. One bit is the standard width and two bits is the optional width.

The result is registered by default, with a valid strobe one clock behind the request. Setting `REG_OUT` to 0 makes the path purely combinational.

Top module: `cap_perm_legalizer`

## Requirements
- R1: The flag vector uses bit 0 = R (read), 1 = W (write), 2 = C (capability access), 3 = LM (load mutable), 4 = EL (elevate level), 5 = X (execute), 6 = ASR (system registers), 7 = M (mode). The R, W, C, X and ASR output flags equal the input flags ANDed with the mask flags.
- R2: The M output is 0 whenever X is 0 after masking; otherwise it equals the masked M.
- R3: The LM output is 0 whenever C is 0 after masking; otherwise it equals the masked LM.
- R4: The store-level output is all zeros whenever C is 0 after masking; otherwise it equals the input store-level ANDed with its mask.
- R5: The EL output is 0 whenever C is 0 after masking; otherwise it equals the masked EL.
- R6: The level output equals the input level ANDed with the level mask, so it is never greater than the input level.
- R7: A single request can both lower the level and clear EL.
- R8: With `REG_OUT`=1, `out_valid` is `in_valid` delayed by one clock and the result appears in that same cycle. Reset clears `out_valid` and all output fields.
- R9: In a cycle with `in_valid` low, the output fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_flags | input | 8 | Current permission flags |
| in_sl | input | LVL_W | Current store-level field (complemented threshold) |
| in_level | input | LVL_W | Current level |
| mask_flags | input | 8 | Flag mask |
| mask_sl | input | LVL_W | Store-level mask |
| mask_level | input | LVL_W | Level mask |
| out_valid | output | 1 | Result strobe |
| out_flags | output | 8 | Legalized flags |
| out_sl | output | LVL_W | Legalized store-level field |
| out_level | output | LVL_W | Reduced level |

## Verification
Every result is due exactly one clock after the request, in the same cycle as `out_valid`. The bench drives each request on a falling edge and lets one rising edge pass. It compares outputs on the next falling edge against a reference model, which it updates only when a request was valid. That same comparison every cycle also covers the hold behaviour in idle cycles.

// File: rtl/cap_perm_legalizer.sv
module cap_perm_legalizer #(
  parameter int LVL_W   = 1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_flags,
  input  logic [LVL_W-1:0] in_sl,
  input  logic [LVL_W-1:0] in_level,
  input  logic [7:0]       mask_flags,
  input  logic [LVL_W-1:0] mask_sl,
  input  logic [LVL_W-1:0] mask_level,
  output logic             out_valid,
  output logic [7:0]       out_flags,
  output logic [LVL_W-1:0] out_sl,
  output logic [LVL_W-1:0] out_level
);
  localparam int B_C  = 2;
  localparam int B_LM = 3;
  localparam int B_EL = 4;
  localparam int B_X  = 5;
  localparam int B_M  = 7;

  logic [7:0]       anded;
  logic [7:0]       legal_flags;
  logic [LVL_W-1:0] legal_sl;
  logic [LVL_W-1:0] legal_level;
  logic             keep_cap;

  assign anded    = in_flags & mask_flags;
  assign keep_cap = anded[B_C];

  always_comb begin
    legal_flags       = anded;
    legal_flags[B_M]  = anded[B_M]  & anded[B_X];
    legal_flags[B_LM] = anded[B_LM] & keep_cap;
    legal_flags[B_EL] = anded[B_EL] & keep_cap;
  end

  assign legal_sl    = keep_cap ? (in_sl & mask_sl) : '0;
  assign legal_level = in_level & mask_level;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_flags <= '0;
          out_sl    <= '0;
          out_level <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_flags <= legal_flags;
            out_sl    <= legal_sl;
            out_level <= legal_level;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_flags = legal_flags;
      assign out_sl    = legal_sl;
      assign out_level = legal_level;
    end
  endgenerate
endmodule

module cap_perm_legalizer_chk #(
  parameter int LVL_W   = 1,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_flags,
  input logic [LVL_W-1:0] in_sl,
  input logic [LVL_W-1:0] in_level,
  input logic [7:0]       mask_flags,
  input logic [LVL_W-1:0] mask_sl,
  input logic [LVL_W-1:0] mask_level,
  input logic             out_valid,
  input logic [7:0]       out_flags,
  input logic [LVL_W-1:0] out_sl,
  input logic [LVL_W-1:0] out_level
);
  p_m_needs_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[7] && !out_flags[5]));
  p_lm_needs_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[3] && !out_flags[2]));
  p_sl_needs_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flags[2]) |-> (out_sl == '0));
  p_el_needs_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[4] && !out_flags[2]));

  generate
    if (REG_OUT) begin : g_seq
      p_no_raise_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_flags & ~$past(in_flags)) == '0));
      p_no_raise_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_level <= $past(in_level)));
      p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_flags) && $stable(out_sl) && $stable(out_level)));
    end
  endgenerate
endmodule

bind cap_perm_legalizer cap_perm_legalizer_chk #(.LVL_W(LVL_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_cap_perm_legalizer.sv
`timescale 1ns/1ps
module test_cap_perm_legalizer;
  localparam int LW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_flags = '0, mask_flags = '0;
  logic [LW-1:0] in_sl = '0, in_level = '0, mask_sl = '0, mask_level = '0;
  logic          out_valid;
  logic [7:0]    out_flags;
  logic [LW-1:0] out_sl, out_level;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0]    e_flags = '0;
  logic [LW-1:0] e_sl = '0, e_level = '0;

  always #2.5 clk = ~clk;

  cap_perm_legalizer #(.LVL_W(LW), .REG_OUT(1'b1)) i_cap_perm_legalizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_flags(in_flags), .in_sl(in_sl), .in_level(in_level),
    .mask_flags(mask_flags), .mask_sl(mask_sl), .mask_level(mask_level),
    .out_valid(out_valid), .out_flags(out_flags), .out_sl(out_sl), .out_level(out_level));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // reference model: flags ANDed, then each dependency applied in turn
  task automatic model_update(logic [7:0] f, logic [7:0] mf, logic [LW-1:0] s,
                              logic [LW-1:0] ms, logic [LW-1:0] l, logic [LW-1:0] ml);
    logic [7:0] r;
    r = f & mf;
    if (r[5] == 1'b0) r[7] = 1'b0;
    if (r[2] == 1'b0) begin
      r[3] = 1'b0;
      r[4] = 1'b0;
      e_sl = '0;
    end else begin
      e_sl = s & ms;
    end
    e_flags = r;
    e_level = l & ml;
  endtask

  task automatic step(logic v, logic [7:0] f, logic [7:0] mf, logic [LW-1:0] s,
                      logic [LW-1:0] ms, logic [LW-1:0] l, logic [LW-1:0] ml);
    in_valid = v; in_flags = f; mask_flags = mf;
    in_sl = s; mask_sl = ms; in_level = l; mask_level = ml;
    @(posedge clk);
    if (v) model_update(f, mf, s, ms, l, ml);
    @(negedge clk);
    chk("R8 valid", 32'(out_valid), 32'(v));
    chk(v ? "R1 R2 R3 R5 flags" : "R9 flags hold", 32'(out_flags), 32'(e_flags));
    chk(v ? "R4 store level" : "R9 store level hold", 32'(out_sl), 32'(e_sl));
    chk(v ? "R6 level" : "R9 level hold", 32'(out_level), 32'(e_level));
  endtask

  initial begin
    #(5.0 * 100000);
    $display("watchdog expired");
    fails++;
    finish_run();
  end

  initial begin
    in_valid = 1'b1; in_flags = 8'hFF; mask_flags = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", 32'(out_valid), 32'd0);
    chk("R8 reset flags", 32'(out_flags), 32'd0);
    chk("R8 reset level", 32'(out_level), 32'd0);
    chk("R8 reset sl", 32'(out_sl), 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full mask keeps everything
    step(1'b1, 8'hFF, 8'hFF, '1, '1, '1, '1);
    chk("R1 all kept", 32'(out_flags), 32'hFF);
    // R2: removing X drops M
    step(1'b1, 8'hFF, 8'hDF, '1, '1, '1, '1);
    chk("R2 M dropped", 32'(out_flags[7]), 32'd0);
    // R3 R4 R5: removing C drops LM, EL and store level
    step(1'b1, 8'hFF, 8'hFB, '1, '1, '1, '1);
    chk("R3 LM dropped", 32'(out_flags[3]), 32'd0);
    chk("R5 EL dropped", 32'(out_flags[4]), 32'd0);
    chk("R4 SL zeroed", 32'(out_sl), 32'd0);
    // R7: lower level and remove EL in one request
    step(1'b1, 8'hFF, 8'hEF, '1, '1, '1, '0);
    chk("R7 EL cleared", 32'(out_flags[4]), 32'd0);
    chk("R7 level lowered", 32'(out_level), 32'd0);
    // R6: a mask of ones never raises a zero level
    step(1'b1, 8'h07, 8'hFF, '0, '1, '0, '1);
    chk("R6 no raise", 32'(out_level), 32'd0);
    // R9: idle cycles with changed inputs leave outputs alone
    step(1'b0, 8'hFF, 8'hFF, '1, '1, '1, '1);
    step(1'b0, 8'h00, 8'h00, '0, '0, '0, '0);
    chk("R9 hold flags", 32'(out_flags), 32'h07);
    // R2 with X kept: M passes
    step(1'b1, 8'hA0, 8'hFF, '0, '0, '0, '0);
    chk("R2 M kept", 32'(out_flags), 32'hA0);

    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 8'($urandom), 8'($urandom), LW'($urandom),
           LW'($urandom), LW'($urandom), LW'($urandom));
    end
    @(negedge clk);
    finish_run();
  end
endmodule